// File: doc/BRIEF.md
# Lockstep Request Legality Gate

This block sits on the AXI read-address and write-address channels just ahead of a memory controller whose data path is built from several controllers running in lockstep. Every request is screened against the rules of the lockstep arrangement chosen by a static mode input. The rules cover the smallest transfer size, address alignment, whether a read may be narrower than the full bus, and how many ID bits the controllers can carry. A request that meets every rule passes straight through with its handshake intact.

A request that breaks a rule is accepted upstream and never forwarded. One clock later the channel raises a one-cycle error pulse. At the same edge it stores a 3-bit cause code that stays put until the next rejection on that channel. The read and write channels are screened by separate copies of the same logic and do not affect each other. The three modes describe, in order: a 40-bit arrangement with two controllers on a 256-bit bus; a 64-bit arrangement that uses the primary controller alone on a 512-bit bus; and a 72-bit arrangement with the secondary controllers on a 512-bit bus.

Top module: `lsreq_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_err` and `wr_err` are 0 and `rd_cause` and `wr_cause` are 0.
- R2: A request that breaks no rule passes combinationally. `*_out_valid` equals `*_in_valid`, `*_in_ready` equals `*_out_ready`, and address, size and ID are copied unchanged.
- R3: A request that breaks a rule is never forwarded. `*_out_valid` is 0 and `*_in_ready` is 1, whatever the value of `*_out_ready`.
- R4: The size code must lie in [min, full]. The mode encoding is 0 for 40-bit (min 2, full 5), 1 for 64-bit (min 1, full 6) and 2 for 72-bit (min 3, full 6). A size outside that range gives cause 1.
- R5: The address must be a multiple of 2^size, that is 2^max(size, min) once R4 holds. Otherwise the cause is 2.
- R6: On the read channel only, a size below the mode's full-width size gives cause 3. The write channel has no such rule.
- R7: IDs are limited to 6 bits in modes 0 and 2 and to 7 bits in mode 1. An ID with any higher bit set gives cause 4.
- R8: When several rules are broken, the reported cause follows this priority: mode (5), then size (1), then alignment (2), then narrow read (3), then ID (4).
- R9: A rejected beat raises the channel's error output for exactly the next cycle. At the same edge the channel's cause register takes the nonzero cause. The cause register holds its value across legal beats and idle cycles.
- R10: Mode 3 is reserved. Every request on both channels is rejected with cause 5.
- R11: The read and write channels are judged independently. A rejection on one channel leaves the other channel's forwarding, error output and cause untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Static lockstep arrangement select |
| ar_in_valid | input | 1 | Read request valid from the initiator |
| ar_in_ready | output | 1 | Read request ready to the initiator |
| ar_in_addr | input | ADDR_W | Read request address |
| ar_in_size | input | 3 | Read request size code (log2 bytes) |
| ar_in_id | input | ID_W | Read request ID |
| ar_out_valid | output | 1 | Read request valid to the controller |
| ar_out_ready | input | 1 | Read request ready from the controller |
| ar_out_addr | output | ADDR_W | Forwarded read address |
| ar_out_size | output | 3 | Forwarded read size code |
| ar_out_id | output | ID_W | Forwarded read ID |
| aw_in_valid | input | 1 | Write request valid from the initiator |
| aw_in_ready | output | 1 | Write request ready to the initiator |
| aw_in_addr | input | ADDR_W | Write request address |
| aw_in_size | input | 3 | Write request size code |
| aw_in_id | input | ID_W | Write request ID |
| aw_out_valid | output | 1 | Write request valid to the controller |
| aw_out_ready | input | 1 | Write request ready from the controller |
| aw_out_addr | output | ADDR_W | Forwarded write address |
| aw_out_size | output | 3 | Forwarded write size code |
| aw_out_id | output | ID_W | Forwarded write ID |
| rd_err | output | 1 | One-cycle pulse after a rejected read request |
| rd_cause | output | 3 | Cause of the latest rejected read request |
| wr_err | output | 1 | One-cycle pulse after a rejected write request |
| wr_cause | output | 3 | Cause of the latest rejected write request |

## Verification
A wrong verdict appears in the same cycle as the request. Either the forwarded valid stays high for a beat that should be dropped, or the upstream ready follows the controller when it should be forced high. A fault in the error or cause registers shows on the next clock edge, as a missing or extra pulse or as a cause that changes without one. For that reason every beat is judged twice: once combinationally before the edge, and once one edge later. The stimulus sweeps every mode, every size code and 64 low-address offsets, with different stimulus on each channel.

// File: rtl/lsreq_pkg.sv
package lsreq_pkg;

   typedef enum logic [1:0] {
      MODE_X40  = 2'd0,
      MODE_X64  = 2'd1,
      MODE_X72  = 2'd2,
      MODE_RSVD = 2'd3
   } ls_mode_e;

   // Encoding is observable at the ports; priority order is R8
   typedef enum logic [2:0] {
      CZ_NONE   = 3'd0,
      CZ_SIZE   = 3'd1,
      CZ_ALIGN  = 3'd2,
      CZ_NARROW = 3'd3,
      CZ_ID     = 3'd4,
      CZ_MODE   = 3'd5
   } cause_e;

   typedef struct packed {
      logic       ok;
      logic [2:0] min_sz;
      logic [2:0] full_sz;
      logic [2:0] id_bits;
   } limits_t;

   function automatic limits_t limits_of(input ls_mode_e m);
      limits_t l;
      case (m)
         MODE_X40: l = '{ok: 1'b1, min_sz: 3'd2, full_sz: 3'd5, id_bits: 3'd6};
         MODE_X64: l = '{ok: 1'b1, min_sz: 3'd1, full_sz: 3'd6, id_bits: 3'd7};
         MODE_X72: l = '{ok: 1'b1, min_sz: 3'd3, full_sz: 3'd6, id_bits: 3'd6};
         default:  l = '{ok: 1'b0, min_sz: 3'd7, full_sz: 3'd0, id_bits: 3'd0};
      endcase
      return l;
   endfunction

endpackage

// File: rtl/lsreq_rules.sv
module lsreq_rules
   import lsreq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int ID_W    = 8,
   parameter bit IS_READ = 1'b1
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic [ID_W-1:0]   id,
   output cause_e            verdict
);

   localparam int ALIGN_SPAN = 8;   // size codes 0..7 reach bit 6 at most

   limits_t lim;
   logic    misaligned;
   logic    id_over;
   logic    size_bad;
   logic    narrow;

   always_comb begin
      lim        = limits_of(ls_mode_e'(mode));
      misaligned = 1'b0;
      for (int b = 0; b < ALIGN_SPAN; b++) begin
         if (b < int'(size)) misaligned = misaligned | addr[b];
      end
      id_over = 1'b0;
      for (int b = 0; b < ID_W; b++) begin
         if (b >= int'(lim.id_bits)) id_over = id_over | id[b];
      end
      size_bad = (size < lim.min_sz) || (size > lim.full_sz);
      narrow   = IS_READ && (size < lim.full_sz);
   end

   // R8: fixed priority chain
   always_comb begin
      if (!lim.ok)         verdict = CZ_MODE;
      else if (size_bad)   verdict = CZ_SIZE;
      else if (misaligned) verdict = CZ_ALIGN;
      else if (narrow)     verdict = CZ_NARROW;
      else if (id_over)    verdict = CZ_ID;
      else                 verdict = CZ_NONE;
   end

endmodule

// File: rtl/lsreq_chan.sv
module lsreq_chan
   import lsreq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int ID_W    = 8,
   parameter bit IS_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [2:0]        in_size,
   input  logic [ID_W-1:0]   in_id,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [2:0]        out_size,
   output logic [ID_W-1:0]   out_id,
   output logic              err,
   output logic [2:0]        cause
);

   cause_e verdict;
   cause_e cause_q;
   logic   legal;
   logic   reject;

   lsreq_rules #(
      .ADDR_W (ADDR_W),
      .ID_W   (ID_W),
      .IS_READ(IS_READ)
   ) u_rules (
      .mode   (mode),
      .addr   (in_addr),
      .size   (in_size),
      .id     (in_id),
      .verdict(verdict)
   );

   assign legal     = (verdict == CZ_NONE);
   assign reject    = in_valid && !legal;
   assign out_valid = in_valid && legal;
   assign in_ready  = legal ? out_ready : 1'b1;   // drop illegal beats
   assign out_addr  = in_addr;
   assign out_size  = in_size;
   assign out_id    = in_id;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err     <= 1'b0;
         cause_q <= CZ_NONE;
      end else begin
         err <= reject;
         if (reject) cause_q <= verdict;
      end
   end

   assign cause = cause_q;

endmodule

// File: rtl/lsreq_gate.sv
module lsreq_gate #(
   parameter int ADDR_W = 16,
   parameter int ID_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              ar_in_valid,
   output logic              ar_in_ready,
   input  logic [ADDR_W-1:0] ar_in_addr,
   input  logic [2:0]        ar_in_size,
   input  logic [ID_W-1:0]   ar_in_id,
   output logic              ar_out_valid,
   input  logic              ar_out_ready,
   output logic [ADDR_W-1:0] ar_out_addr,
   output logic [2:0]        ar_out_size,
   output logic [ID_W-1:0]   ar_out_id,
   input  logic              aw_in_valid,
   output logic              aw_in_ready,
   input  logic [ADDR_W-1:0] aw_in_addr,
   input  logic [2:0]        aw_in_size,
   input  logic [ID_W-1:0]   aw_in_id,
   output logic              aw_out_valid,
   input  logic              aw_out_ready,
   output logic [ADDR_W-1:0] aw_out_addr,
   output logic [2:0]        aw_out_size,
   output logic [ID_W-1:0]   aw_out_id,
   output logic              rd_err,
   output logic [2:0]        rd_cause,
   output logic              wr_err,
   output logic [2:0]        wr_cause
);

   localparam int N_CH     = 2;   // 0: read address, 1: write address
   localparam int MIN_ADDR = 8;
   localparam int MIN_ID   = 7;

   if (ADDR_W < MIN_ADDR) begin : g_bad_addr
      $error("lsreq_gate: ADDR_W must cover the widest alignment span");
   end
   if (ID_W < MIN_ID) begin : g_bad_id
      $error("lsreq_gate: ID_W must hold at least the widest legal ID");
   end

   logic              c_in_valid  [N_CH];
   logic              c_in_ready  [N_CH];
   logic [ADDR_W-1:0] c_in_addr   [N_CH];
   logic [2:0]        c_in_size   [N_CH];
   logic [ID_W-1:0]   c_in_id     [N_CH];
   logic              c_out_valid [N_CH];
   logic              c_out_ready [N_CH];
   logic [ADDR_W-1:0] c_out_addr  [N_CH];
   logic [2:0]        c_out_size  [N_CH];
   logic [ID_W-1:0]   c_out_id    [N_CH];
   logic              c_err       [N_CH];
   logic [2:0]        c_cause     [N_CH];

   assign c_in_valid[0]  = ar_in_valid;
   assign c_in_addr[0]   = ar_in_addr;
   assign c_in_size[0]   = ar_in_size;
   assign c_in_id[0]     = ar_in_id;
   assign c_out_ready[0] = ar_out_ready;
   assign c_in_valid[1]  = aw_in_valid;
   assign c_in_addr[1]   = aw_in_addr;
   assign c_in_size[1]   = aw_in_size;
   assign c_in_id[1]     = aw_in_id;
   assign c_out_ready[1] = aw_out_ready;

   // R11: one independent screening lane per address channel
   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      lsreq_chan #(
         .ADDR_W (ADDR_W),
         .ID_W   (ID_W),
         .IS_READ(ch == 0)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (mode),
         .in_valid (c_in_valid[ch]),
         .in_ready (c_in_ready[ch]),
         .in_addr  (c_in_addr[ch]),
         .in_size  (c_in_size[ch]),
         .in_id    (c_in_id[ch]),
         .out_valid(c_out_valid[ch]),
         .out_ready(c_out_ready[ch]),
         .out_addr (c_out_addr[ch]),
         .out_size (c_out_size[ch]),
         .out_id   (c_out_id[ch]),
         .err      (c_err[ch]),
         .cause    (c_cause[ch])
      );
   end

   assign ar_in_ready  = c_in_ready[0];
   assign ar_out_valid = c_out_valid[0];
   assign ar_out_addr  = c_out_addr[0];
   assign ar_out_size  = c_out_size[0];
   assign ar_out_id    = c_out_id[0];
   assign rd_err       = c_err[0];
   assign rd_cause     = c_cause[0];
   assign aw_in_ready  = c_in_ready[1];
   assign aw_out_valid = c_out_valid[1];
   assign aw_out_addr  = c_out_addr[1];
   assign aw_out_size  = c_out_size[1];
   assign aw_out_id    = c_out_id[1];
   assign wr_err       = c_err[1];
   assign wr_cause     = c_cause[1];

endmodule

// File: rtl/lsreq_gate_chk.sv
module lsreq_gate_chk #(
   parameter int ID_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      mode,
   input logic            ar_in_valid,
   input logic            ar_in_ready,
   input logic            ar_out_valid,
   input logic [2:0]      ar_out_size,
   input logic            aw_in_valid,
   input logic            aw_in_ready,
   input logic            aw_out_valid,
   input logic [ID_W-1:0] aw_out_id,
   input logic            rd_err,
   input logic [2:0]      rd_cause,
   input logic            wr_err,
   input logic [2:0]      wr_cause
);

   AST_RD_DROP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> $past(ar_in_valid && ar_in_ready && !ar_out_valid)); // R3
   AST_WR_DROP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(aw_in_valid && aw_in_ready && !aw_out_valid)); // R3
   AST_RD_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_err |-> $stable(rd_cause)); // R9
   AST_WR_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_err |-> $stable(wr_cause)); // R9
   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_err || wr_err) |-> ((!rd_err || rd_cause != 3'd0) && (!wr_err || wr_cause != 3'd0))); // R9
   AST_NO_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_out_valid && mode == 2'd0) |-> (ar_out_size == 3'd5)); // R6
   AST_ID_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_out_valid && mode != 2'd1) |-> (aw_out_id[ID_W-1:6] == '0)); // R7
   AST_RSVD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3) |-> (!ar_out_valid && !aw_out_valid)); // R10

endmodule

bind lsreq_gate lsreq_gate_chk #(.ID_W(ID_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .ar_in_valid (ar_in_valid),
   .ar_in_ready (ar_in_ready),
   .ar_out_valid(ar_out_valid),
   .ar_out_size (ar_out_size),
   .aw_in_valid (aw_in_valid),
   .aw_in_ready (aw_in_ready),
   .aw_out_valid(aw_out_valid),
   .aw_out_id   (aw_out_id),
   .rd_err      (rd_err),
   .rd_cause    (rd_cause),
   .wr_err      (wr_err),
   .wr_cause    (wr_cause)
);

// File: tb/lsreq_gate_tb.sv
module lsreq_gate_tb;

   localparam int ADDR_W = 16;
   localparam int ID_W   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode = 2'd0;
   logic              ar_in_valid = 1'b0, aw_in_valid = 1'b0;
   logic              ar_in_ready, aw_in_ready;
   logic [ADDR_W-1:0] ar_in_addr = '0, aw_in_addr = '0;
   logic [2:0]        ar_in_size = '0, aw_in_size = '0;
   logic [ID_W-1:0]   ar_in_id = '0, aw_in_id = '0;
   logic              ar_out_valid, aw_out_valid;
   logic              ar_out_ready = 1'b1, aw_out_ready = 1'b1;
   logic [ADDR_W-1:0] ar_out_addr, aw_out_addr;
   logic [2:0]        ar_out_size, aw_out_size;
   logic [ID_W-1:0]   ar_out_id, aw_out_id;
   logic              rd_err, wr_err;
   logic [2:0]        rd_cause, wr_cause;

   int n_cmp = 0;
   int n_bad = 0;
   int last_r = 0;
   int last_w = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   lsreq_gate #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dut (.*);

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_cause(int md, int sz, int ad, int id, bit rd);
      int mn, fl, ib;
      case (md)
         0: begin mn = 2; fl = 5; ib = 6; end
         1: begin mn = 1; fl = 6; ib = 7; end
         2: begin mn = 3; fl = 6; ib = 6; end
         default: return 5;                    // R10
      endcase
      if (sz < mn || sz > fl) return 1;        // R4
      if ((ad % (1 << sz)) != 0) return 2;     // R5
      if (rd && sz < fl) return 3;             // R6
      if (id >= (1 << ib)) return 4;           // R7
      return 0;
   endfunction

   function automatic string tag_of(int c);
      case (c)
         0: return "R2";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic step(input int md, input int rsz, input int rad, input int rid,
                       input int wsz, input int wad, input int wid, input bit rdy);
      int er, ew;
      @(negedge clk);
      mode = md[1:0];
      ar_in_valid = 1'b1; ar_in_size = rsz[2:0]; ar_in_addr = rad[ADDR_W-1:0]; ar_in_id = rid[ID_W-1:0];
      aw_in_valid = 1'b1; aw_in_size = wsz[2:0]; aw_in_addr = wad[ADDR_W-1:0]; aw_in_id = wid[ID_W-1:0];
      ar_out_ready = rdy; aw_out_ready = !rdy;
      #1;
      er = exp_cause(md, rsz, rad, rid, 1'b1);
      ew = exp_cause(md, wsz, wad, wid, 1'b0);
      check(er == 0 ? "R2 rd valid" : "R3 rd valid", int'(ar_out_valid), int'(er == 0));
      check(er == 0 ? "R2 rd ready" : "R3 rd ready", int'(ar_in_ready), er == 0 ? int'(rdy) : 1);
      if (er == 0) check("R2 rd addr", int'(ar_out_addr), rad);
      check(ew == 0 ? "R11 wr valid" : "R3 wr valid", int'(aw_out_valid), int'(ew == 0));
      check(ew == 0 ? "R11 wr ready" : "R3 wr ready", int'(aw_in_ready), ew == 0 ? int'(!rdy) : 1);
      if (ew == 0) check("R2 wr id", int'(aw_out_id), wid);
      @(posedge clk); #1;
      check("R9 rd_err", int'(rd_err), int'(er != 0));
      if (er != 0) last_r = er;
      check(er != 0 ? tag_of(er) : "R9 rd hold", int'(rd_cause), last_r);
      check("R11 wr_err", int'(wr_err), int'(ew != 0));
      if (ew != 0) last_w = ew;
      check(ew != 0 ? tag_of(ew) : "R9 wr hold", int'(wr_cause), last_w);
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      ar_in_valid = 1'b0; aw_in_valid = 1'b0;
      #1;
      check("R3 idle rd valid", int'(ar_out_valid), 0);
      @(posedge clk); #1;
      check("R9 idle rd_err", int'(rd_err), 0);
      check("R9 idle rd hold", int'(rd_cause), last_r);
      check("R9 idle wr hold", int'(wr_cause), last_w);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1;
      check("R1 rd_err", int'(rd_err), 0);
      check("R1 wr_err", int'(wr_err), 0);
      check("R1 rd_cause", int'(rd_cause), 0);
      check("R1 wr_cause", int'(wr_cause), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 rd_err after release", int'(rd_err), 0);
      check("R1 wr_cause after release", int'(wr_cause), 0);

      // R8: directed priority cases
      step(0, 1, 1, 8'h80, 3, 8, 8'h00, 1'b1);   // size beats align and ID
      step(1, 3, 4, 8'h00, 1, 1, 8'h7F, 1'b1);   // align beats narrow
      step(2, 3, 8, 8'hC0, 3, 8, 8'h40, 1'b0);   // narrow beats ID on read
      idle_cycle();

      for (int md = 0; md < 4; md++) begin
         for (int sz = 0; sz < 8; sz++) begin
            for (int a = 0; a < 64; a++) begin
               int rid, wid;
               rid = ((a >> 4) == 3) ? 8'h80 : (((a >> 4) == 2) ? 8'h40 : a);
               wid = (a % 2 == 1) ? 8'h7F : 8'h3F;
               step(md, sz, 16'h1200 + a, rid, 7 - sz, 16'h3400 + a, wid, (a % 5) != 0);
            end
         end
         idle_cycle();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule